// File: doc/BRIEF.md
# Register Pointer and Command Decoder

This block sits above a byte-level serial slave whose bit timing, START and STOP handling are already done elsewhere. Each command byte from a send-byte transfer is classified against a fixed address map. A configuration code is loaded into an address pointer. A code that names one of four sample-buffer bases switches the block into a burst buffer-read mode. Any other code is refused with a NACK.

For receive-byte transfers the block presents a data byte. In normal mode the byte comes from a small configuration storage array at the pointer, and the pointer steps forward by one after each byte, wrapping to zero above the top address. In buffer mode the byte is passed through from the external buffer block, and a read strobe plus a buffer index are given to that block. The pointer stays frozen in this mode. A NACK from the master after a byte ends buffer mode.

Top module: `regptr_decoder`

## Requirements
- R1: After reset the pointer is 0x00, buffer mode is off (`buf_mode`=0), `resp_valid` is 0, and `rd_data` shows the value of address 0x00, which is 0xA5.
- R2: A command code from 0x00 to 0x45 gives `resp_valid`=1 and `resp_ack`=1 in the cycle after `cmd_valid`. It loads the pointer with that code and leaves buffer mode off. Configuration address a reads as a XOR 0xA5.
- R3: A command code from 0x46 to 0x49 is acknowledged in the same way. It turns `buf_mode` on, and `buf_sel` becomes code minus 0x46.
- R4: A command code of 0x4A or above gives `resp_valid`=1 and `resp_ack`=0. Both the pointer and the mode stay as they were.
- R5: In normal mode, each `byte_done` pulse raises the pointer by one. This happens whether or not `byte_nack` is set.
- R6: A `byte_done` at pointer 0x49 wraps the pointer to 0x00. In normal mode, addresses 0x46 to 0x49 read as 0x00.
- R7: In buffer mode, `rd_data` equals `buf_data`. `buf_rd` is high in each cycle that has `byte_done`, and the pointer does not change.
- R8: In buffer mode, a `byte_done` with `byte_nack`=1 ends buffer mode. Later reads are normal reads that start at the base address that was held.
- R9: If `cmd_valid` and `byte_done` occur in the same cycle, the command takes effect, the read has no effect on the pointer or the mode, and `buf_rd` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle pulse: a command byte was received |
| cmd_code | input | 8 | Command byte value |
| byte_done | input | 1 | One-cycle pulse: a read byte was shifted out |
| byte_nack | input | 1 | The master NACKed the byte marked by `byte_done` |
| buf_data | input | 8 | Sample byte from the buffer block |
| resp_valid | output | 1 | The acknowledge result for the last command is valid |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |
| rd_data | output | 8 | Byte to be sent for the next read |
| buf_mode | output | 1 | Buffer burst-read mode is active |
| buf_sel | output | 2 | Buffer index toward the buffer block |
| buf_rd | output | 1 | Strobe: one buffer byte was consumed |

## Verification
Two things can meet in one cycle: a command load and a byte-read advance. The bench provokes this on purpose by raising `cmd_valid` and `byte_done` together, in normal mode and in buffer mode. It then judges the result only at the ports. `buf_rd` must stay low in that cycle. The acknowledge must match the command. Later reads must show that the pointer and the mode come only from the command. Random mixes of commands and reads also check every byte returned against a bench model.

// File: rtl/regptr_pkg.sv
// Package: shared types and the reset content of the configuration storage.
// Assumes 8-bit data and addresses.
package regptr_pkg;
    typedef enum logic [1:0] {
        CMD_CFG = 2'd0,
        CMD_BUF = 2'd1,
        CMD_BAD = 2'd2
    } cmd_kind_e;

    // Reset value of configuration address a.
    function automatic logic [7:0] cfg_reset_value(input int unsigned a);
        return 8'(a) ^ 8'hA5;
    endfunction
endpackage

// File: rtl/regptr_cmd_decode.sv
// Sorts a command code into configuration, buffer base, or invalid.
// Purely combinational. Assumes BUF_BASE = CFG_TOP + 1.
module regptr_cmd_decode
    import regptr_pkg::*;
#(
    parameter int AW       = 8,
    parameter int CFG_TOP  = 8'h45,
    parameter int BUF_BASE = 8'h46,
    parameter int BUF_CNT  = 4
) (
    input  logic [AW-1:0] code,
    output cmd_kind_e     kind
);
    localparam logic [AW-1:0] CFG_LAST = AW'(CFG_TOP);
    localparam logic [AW-1:0] BUF_LAST = AW'(BUF_BASE + BUF_CNT - 1);

    // Range comparison against the address map.
    always_comb begin
        if (code <= CFG_LAST)      kind = CMD_CFG;
        else if (code <= BUF_LAST) kind = CMD_BUF;
        else                       kind = CMD_BAD;
    end
endmodule

// File: rtl/regptr_store.sv
// Configuration storage array, loaded with fixed values at reset.
// Assumes reads are combinational. Addresses beyond the array read as zero.
module regptr_store
    import regptr_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 70
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [7:0]    rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    // Load the reset content. There is no write path in this block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= cfg_reset_value(i);
        end
    end

    // Read at the address, or return zero outside the array.
    always_comb begin
        if (addr < AW'(DEPTH)) rdata = mem[addr[IW-1:0]];
        else                   rdata = 8'h00;
    end
endmodule

// File: rtl/regptr_ptr_unit.sv
// Holds the address pointer, the buffer-mode flag and the command response.
// A command has priority over a byte advance in the same cycle.
// Assumes cmd_valid and byte_done are one-cycle pulses.
module regptr_ptr_unit
    import regptr_pkg::*;
#(
    parameter int AW      = 8,
    parameter int TOP_ADR = 8'h49
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_code,
    input  cmd_kind_e     cmd_kind,
    input  logic          byte_done,
    input  logic          byte_nack,
    output logic [AW-1:0] ptr,
    output logic          buf_mode,
    output logic          resp_valid,
    output logic          resp_ack
);
    localparam logic [AW-1:0] TOP = AW'(TOP_ADR);

    // Register the response and update the pointer and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            buf_mode   <= 1'b0;
            resp_valid <= 1'b0;
            resp_ack   <= 1'b0;
        end else begin
            resp_valid <= cmd_valid;
            resp_ack   <= cmd_valid && (cmd_kind != CMD_BAD);
            if (cmd_valid) begin
                case (cmd_kind)
                    CMD_CFG: begin ptr <= cmd_code; buf_mode <= 1'b0; end
                    CMD_BUF: begin ptr <= cmd_code; buf_mode <= 1'b1; end
                    default: ;
                endcase
            end else if (byte_done) begin
                if (buf_mode) begin
                    if (byte_nack) buf_mode <= 1'b0;
                end else begin
                    ptr <= (ptr == TOP) ? '0 : ptr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/regptr_decoder.sv
// Top module: register pointer and command decoder for a byte-level slave.
// Chooses the read byte from storage or from the buffer block, and drives the
// buffer strobe and index. Assumes the byte interface below it gives pulses.
module regptr_decoder
    import regptr_pkg::*;
#(
    parameter int AW       = 8,
    parameter int CFG_TOP  = 8'h45,
    parameter int BUF_CNT  = 4,
    parameter int SEL_W    = $clog2(BUF_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [AW-1:0]    cmd_code,
    input  logic             byte_done,
    input  logic             byte_nack,
    input  logic [7:0]       buf_data,
    output logic             resp_valid,
    output logic             resp_ack,
    output logic [7:0]       rd_data,
    output logic             buf_mode,
    output logic [SEL_W-1:0] buf_sel,
    output logic             buf_rd
);
    localparam int BUF_BASE = CFG_TOP + 1;
    localparam int TOP_ADR  = BUF_BASE + BUF_CNT - 1;
    localparam int DEPTH    = CFG_TOP + 1;

    cmd_kind_e     kind;
    logic [AW-1:0] ptr_q;
    logic [7:0]    store_data;
    logic [AW-1:0] sel_wide;

    regptr_cmd_decode #(.AW(AW), .CFG_TOP(CFG_TOP), .BUF_BASE(BUF_BASE), .BUF_CNT(BUF_CNT))
        u_dec (.code(cmd_code), .kind(kind));

    regptr_ptr_unit #(.AW(AW), .TOP_ADR(TOP_ADR)) u_ptr (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_kind(kind), .byte_done(byte_done), .byte_nack(byte_nack),
        .ptr(ptr_q), .buf_mode(buf_mode), .resp_valid(resp_valid), .resp_ack(resp_ack)
    );

    regptr_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(ptr_q), .rdata(store_data)
    );

    // Choose the read source and form the outputs toward the buffer block.
    always_comb begin
        sel_wide = ptr_q - AW'(BUF_BASE);
        buf_sel  = sel_wide[SEL_W-1:0];
        rd_data  = buf_mode ? buf_data : store_data;
        buf_rd   = byte_done && buf_mode && !cmd_valid;
    end
endmodule

// File: rtl/regptr_decoder_chk.sv
// Checker bound to regptr_decoder. Checks the pointer and mode rules over time.
module regptr_decoder_chk #(
    parameter int AW      = 8,
    parameter int CFG_TOP = 8'h45,
    parameter int BUF_CNT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [AW-1:0] cmd_code,
    input logic          byte_done,
    input logic          byte_nack,
    input logic [AW-1:0] ptr_q,
    input logic          buf_mode,
    input logic          resp_ack,
    input logic          buf_rd
);
    localparam logic [AW-1:0] TOP  = AW'(CFG_TOP + BUF_CNT);
    localparam logic [AW-1:0] BASE = AW'(CFG_TOP + 1);

    a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code < BASE |=> ptr_q == $past(cmd_code) && !buf_mode && resp_ack);
    a_r3_buf_enter: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code >= BASE && cmd_code <= TOP |=> buf_mode && resp_ack);
    a_r4_nack_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code > TOP |=> !resp_ack && ptr_q == $past(ptr_q) && buf_mode == $past(buf_mode));
    a_r5_increment: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && !cmd_valid && !buf_mode && ptr_q != TOP |=> ptr_q == $past(ptr_q) + 1'b1);
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && !cmd_valid && !buf_mode && ptr_q == TOP |=> ptr_q == '0);
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        buf_mode && !cmd_valid |=> $stable(ptr_q));
    a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
        buf_mode && byte_done && byte_nack && !cmd_valid |=> !buf_mode);
    a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !buf_rd);
endmodule

bind regptr_decoder regptr_decoder_chk #(.AW(AW), .CFG_TOP(CFG_TOP), .BUF_CNT(BUF_CNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .byte_done(byte_done), .byte_nack(byte_nack), .ptr_q(ptr_q),
    .buf_mode(buf_mode), .resp_ack(resp_ack), .buf_rd(buf_rd)
);

// File: tb/sim_regptr_decoder.sv
module sim_regptr_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, byte_done = 1'b0, byte_nack = 1'b0;
    logic [7:0] cmd_code = 8'h00, buf_data = 8'h00;
    logic resp_valid, resp_ack, buf_mode, buf_rd;
    logic [7:0] rd_data;
    logic [1:0] buf_sel;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] m_ptr = 8'h00;
    logic       m_mode = 1'b0;

    regptr_decoder u0 (.*);

    always #5 clk = ~clk;

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] exp_read(input logic [7:0] p, input logic md, input logic [7:0] bd);
        if (md) return bd;
        if (p <= 8'h45) return p ^ 8'hA5;
        return 8'h00;
    endfunction

    function automatic int kind_of(input logic [7:0] c);
        if (c <= 8'h45) return 0;
        if (c <= 8'h49) return 1;
        return 2;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " mode"}, 32'(buf_mode), 32'(m_mode));
        check({req, " rd_data"}, 32'(rd_data), 32'(exp_read(m_ptr, m_mode, buf_data)));
        if (m_mode) check({req, " sel"}, 32'(buf_sel), 32'(m_ptr - 8'h46));
    endtask

    task automatic model_cmd(input logic [7:0] c);
        case (kind_of(c))
            0: begin m_ptr = c; m_mode = 1'b0; end
            1: begin m_ptr = c; m_mode = 1'b1; end
            default: ;
        endcase
    endtask

    // Send a command byte, optionally with a read in the same cycle (R9).
    task automatic do_cmd(input logic [7:0] c, input logic with_read, input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; byte_done = with_read; byte_nack = with_read;
        #1;
        check({req, " R9 strobe"}, 32'(buf_rd), 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0; byte_done = 1'b0; byte_nack = 1'b0;
        check({req, " resp_valid"}, 32'(resp_valid), 32'd1);
        check({req, " resp_ack"}, 32'(resp_ack), 32'(kind_of(c) != 2));
        model_cmd(c);
        check_state(req);
    endtask

    // One receive-byte read: checks the byte and the strobe, then advances the model.
    task automatic do_read(input logic nk, input string req);
        @(negedge clk);
        buf_data = 8'($urandom);
        byte_done = 1'b1; byte_nack = nk;
        #1;
        check({req, " R7 byte"}, 32'(rd_data), 32'(exp_read(m_ptr, m_mode, buf_data)));
        check({req, " R7 strobe"}, 32'(buf_rd), 32'(m_mode));
        @(negedge clk);
        byte_done = 1'b0; byte_nack = 1'b0;
        if (m_mode) begin
            if (nk) m_mode = 1'b0;
        end else begin
            m_ptr = (m_ptr == 8'h49) ? 8'h00 : m_ptr + 8'h01;
        end
        check_state(req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 ptr value", 32'(rd_data), 32'hA5);
        check("R1 mode", 32'(buf_mode), 32'd0);
        check("R1 resp_valid", 32'(resp_valid), 32'd0);

        // R2: configuration loads, edges of the range
        do_cmd(8'h00, 1'b0, "R2 low");
        do_cmd(8'h45, 1'b0, "R2 top");
        do_read(1'b0, "R5 step");
        // R6: addresses 0x46..0x49 read as zero, then wrap
        do_read(1'b1, "R5 nack still steps");
        do_read(1'b0, "R6 zero");
        do_read(1'b0, "R6 zero");
        do_read(1'b0, "R6 wrap");
        check("R6 wrapped", 32'(rd_data), 32'hA5);
        // R4: invalid codes leave state
        do_cmd(8'h10, 1'b0, "R2 mid");
        do_cmd(8'h4A, 1'b0, "R4 first bad");
        do_cmd(8'hFF, 1'b0, "R4 max bad");
        // R3/R7/R8: buffer burst, exit, resume normal from base
        do_cmd(8'h47, 1'b0, "R3 enter");
        do_cmd(8'h80, 1'b0, "R4 bad in buffer");
        do_read(1'b0, "R7 burst");
        do_read(1'b0, "R7 burst");
        do_read(1'b1, "R8 exit");
        do_read(1'b0, "R8 resume 0x47");
        do_read(1'b0, "R8 resume 0x48");
        do_read(1'b0, "R8 resume 0x49");
        check("R8 pointer held at base", 32'(rd_data), 32'hA5);
        // R9: command and read in one cycle, both modes
        do_cmd(8'h20, 1'b1, "R9 normal");
        do_cmd(8'h49, 1'b1, "R9 into buffer");
        do_cmd(8'h46, 1'b1, "R9 in buffer");
        do_cmd(8'h05, 1'b1, "R9 leave buffer");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom % 10);
            if (r < 2)      do_cmd(8'($urandom % 70), r == 1, "R2 rand");
            else if (r < 3) do_cmd(8'h46 + 8'($urandom % 4), 1'b0, "R3 rand");
            else if (r < 4) do_cmd(8'h4A + 8'($urandom % 182), 1'b0, "R4 rand");
            else            do_read(($urandom % 6) == 0, "R5 rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule